// File: doc/BRIEF.md
# Reservation Station with Built-in Execution Unit

This block parks integer operations for a 32-bit out-of-order core until their source operands are known, then runs them through an execution unit that sits inside the same module. Each cycle the instruction unit can hand over one operation. The operation carries a 4-bit operation code, a 4-bit reorder-buffer tag that names its result, and two operands. Each operand is either a 32-bit value or a wait on the tag of the operation that will produce it.

Operands that are waiting watch two result broadcasts. One comes from the load/store buffer. The other is the station's own result from the previous cycle, fed back inside the block. Once both operands of an entry hold values, the entry can issue. The lowest-numbered ready slot issues each cycle. Its result is registered and then presented with its tag on the result port one cycle later. That same registered result is also the internal broadcast for the cycle that follows.

The `full` output throttles the instruction unit. The `run_en` input freezes the whole block when it is low.

Top module: `rsa_station`

## Requirements
- R1: While `rst` is high at a rising edge, all slots are emptied and `res_valid` is cleared. After reset, `full` is low, and an operation that was pending before the reset never produces a result.
- R2: With `run_en` high, `in_valid` high and `full` low, the operation is stored in the lowest-numbered free slot at the rising edge. An operand whose wait flag is low is held as the value given.
- R3: At each rising edge with `run_en` high, at most one slot whose two operands both hold values is issued: the lowest-numbered such slot. Its result appears on `res_valid`, `res_tag` and `res_data` right after the following edge. Entries that become ready together leave in slot order.
- R4: The operation codes are: 0 add, 1 subtract (a-b), 2 xor, 3 or, 4 and, 5 shift a left, 6 shift a right with zero fill, 7 shift a right with sign fill, 8 equal, 9 not equal, 10 signed less-than, 11 unsigned less-than, 12 signed greater-or-equal, 13 unsigned greater-or-equal. Shift amounts are taken from the low 5 bits of b. Comparisons return 1 or 0.
- R5: Operation codes 14 and 15 produce a result of 0, issued and tagged like any other operation.
- R6: When `mem_valid` is high at a rising edge, every stored waiting operand whose producer tag equals `mem_tag` takes `mem_data` and stops waiting.
- R7: While `res_valid` is high at a rising edge, every stored waiting operand whose producer tag equals `res_tag` takes `res_data` and stops waiting.
- R8: An operand arriving with its wait flag high, whose producer tag matches a broadcast active in that same cycle (load/store or own result), is stored already holding the broadcast value.
- R9: `full` is high whenever at most one slot is free. An operation presented while `full` is high is discarded.
- R10: While `run_en` is low, no operation is stored, issued or woken, and the result port holds its value.
- R11: After an edge with `run_en` high at which no slot was ready, `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Block advances only while high |
| in_valid | input | 1 | New operation offered |
| in_op | input | 4 | Operation code |
| in_tag | input | 4 | Reorder-buffer tag of the result |
| in_a | input | 32 | First operand value |
| in_a_wait | input | 1 | First operand still awaits a producer |
| in_a_src | input | 4 | Producer tag of first operand |
| in_b | input | 32 | Second operand value |
| in_b_wait | input | 1 | Second operand still awaits a producer |
| in_b_src | input | 4 | Producer tag of second operand |
| full | output | 1 | No new operation may be offered |
| res_valid | output | 1 | A result is presented and broadcast |
| res_tag | output | 4 | Tag of the presented result |
| res_data | output | 32 | Presented result value |
| mem_valid | input | 1 | Load/store buffer broadcast valid |
| mem_tag | input | 4 | Tag of the load/store broadcast |
| mem_data | input | 32 | Value of the load/store broadcast |

## Verification
The checker relies on the load/store buffer and the station's own result never broadcasting the same tag in one cycle. It also relies on each tag having only one outstanding producer at a time, and on the instruction unit respecting `full` except when that case is tested deliberately. The stimulus keeps these conditions. It picks fresh tags for every pending producer, and tags that drive a load/store broadcast never match a result then on the result port. The one deliberate add under `full` is checked only for its lack of effect.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

  localparam int RSA_OP_W = 4;

  typedef enum logic [RSA_OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_XOR  = 4'd2,
    OP_OR   = 4'd3,
    OP_AND  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHRL = 4'd6,
    OP_SHRA = 4'd7,
    OP_EQ   = 4'd8,
    OP_NE   = 4'd9,
    OP_LTS  = 4'd10,
    OP_LTU  = 4'd11,
    OP_GES  = 4'd12,
    OP_GEU  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } rsa_op_e;

endpackage

// File: rtl/rsa_pick.sv
module rsa_pick #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |req;
  assign grant = any ? (N'(1) << idx) : '0;

endmodule

// File: rtl/rsa_slot.sv
module rsa_slot #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              wr_en,
  input  logic [OP_W-1:0]   wr_op,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_a,
  input  logic              wr_a_wait,
  input  logic [TAG_W-1:0]  wr_a_src,
  input  logic [DATA_W-1:0] wr_b,
  input  logic              wr_b_wait,
  input  logic [TAG_W-1:0]  wr_b_src,
  input  logic              clr_en,
  input  logic              bc0_valid,
  input  logic [TAG_W-1:0]  bc0_tag,
  input  logic [DATA_W-1:0] bc0_data,
  input  logic              bc1_valid,
  input  logic [TAG_W-1:0]  bc1_tag,
  input  logic [DATA_W-1:0] bc1_data,
  output logic              valid,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  tag,
  output logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] b
);

  logic             a_wait, b_wait;
  logic [TAG_W-1:0] a_src, b_src;

  logic a_hit0, a_hit1, b_hit0, b_hit1;

  assign a_hit0 = valid && a_wait && bc0_valid && (a_src == bc0_tag);
  assign a_hit1 = valid && a_wait && bc1_valid && (a_src == bc1_tag);
  assign b_hit0 = valid && b_wait && bc0_valid && (b_src == bc0_tag);
  assign b_hit1 = valid && b_wait && bc1_valid && (b_src == bc1_tag);

  assign ready = valid && !a_wait && !b_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      op     <= '0;
      tag    <= '0;
      a      <= '0;
      b      <= '0;
      a_wait <= 1'b0;
      b_wait <= 1'b0;
      a_src  <= '0;
      b_src  <= '0;
    end else if (run_en) begin
      if (wr_en) begin
        valid  <= 1'b1;
        op     <= wr_op;
        tag    <= wr_tag;
        a      <= wr_a;
        a_wait <= wr_a_wait;
        a_src  <= wr_a_src;
        b      <= wr_b;
        b_wait <= wr_b_wait;
        b_src  <= wr_b_src;
      end else begin
        if (clr_en) valid <= 1'b0;
        if (a_hit0) begin
          a      <= bc0_data;
          a_wait <= 1'b0;
        end else if (a_hit1) begin
          a      <= bc1_data;
          a_wait <= 1'b0;
        end
        if (b_hit0) begin
          b      <= bc0_data;
          b_wait <= 1'b0;
        end else if (b_hit1) begin
          b      <= bc1_data;
          b_wait <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rsa_alu.sv
module rsa_alu #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              go,
  input  logic [OP_W-1:0]   op,
  input  logic [TAG_W-1:0]  tag,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data
);
  import rsa_pkg::*;

  localparam int SH_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] flag(input logic c);
    return {{(DATA_W-1){1'b0}}, c};
  endfunction

  function automatic logic [DATA_W-1:0] alu_eval(
    input logic [OP_W-1:0]   f,
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y
  );
    logic [SH_W-1:0] sh;
    sh = y[SH_W-1:0];
    case (f)
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_XOR:  return x ^ y;
      OP_OR:   return x | y;
      OP_AND:  return x & y;
      OP_SHL:  return x << sh;
      OP_SHRL: return x >> sh;
      OP_SHRA: return $signed(x) >>> sh;
      OP_EQ:   return flag(x == y);
      OP_NE:   return flag(x != y);
      OP_LTS:  return flag($signed(x) < $signed(y));
      OP_LTU:  return flag(x < y);
      OP_GES:  return flag($signed(x) >= $signed(y));
      OP_GEU:  return flag(x >= y);
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_data  <= '0;
    end else if (run_en) begin
      res_valid <= go;
      if (go) begin
        res_tag  <= tag;
        res_data <= alu_eval(op, a, b);
      end
    end
  end

endmodule

// File: rtl/rsa_station.sv
module rsa_station #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_a,
  input  logic              in_a_wait,
  input  logic [TAG_W-1:0]  in_a_src,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_b_wait,
  input  logic [TAG_W-1:0]  in_b_src,
  output logic              full,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data,
  input  logic              mem_valid,
  input  logic [TAG_W-1:0]  mem_tag,
  input  logic [DATA_W-1:0] mem_data
);

  localparam int DEPTH = 1 << SLOT_W;
  localparam int CNT_W = SLOT_W + 1;

  // internal events, named for the checker
  logic [DEPTH-1:0]  valid_vec;
  logic [DEPTH-1:0]  ready_vec;
  logic [DEPTH-1:0]  issue_vec;
  logic [SLOT_W-1:0] issue_idx;
  logic              issue_any;
  logic [DEPTH-1:0]  free_onehot;
  logic [SLOT_W-1:0] add_slot;
  logic              free_any;
  logic              add_fire;
  logic [CNT_W-1:0]  free_cnt;

  logic [OP_W-1:0]   s_op  [DEPTH];
  logic [TAG_W-1:0]  s_tag [DEPTH];
  logic [DATA_W-1:0] s_a   [DEPTH];
  logic [DATA_W-1:0] s_b   [DEPTH];

  // capture an incoming operand from a same-cycle broadcast: {wait, value}
  function automatic logic [DATA_W:0] bypass(
    input logic              w,
    input logic [TAG_W-1:0]  src,
    input logic [DATA_W-1:0] val,
    input logic              m_v,
    input logic [TAG_W-1:0]  m_t,
    input logic [DATA_W-1:0] m_d,
    input logic              r_v,
    input logic [TAG_W-1:0]  r_t,
    input logic [DATA_W-1:0] r_d
  );
    if (w && m_v && (src == m_t)) return {1'b0, m_d};
    if (w && r_v && (src == r_t)) return {1'b0, r_d};
    return {w, val};
  endfunction

  logic [DATA_W:0] cap_a, cap_b;

  assign cap_a = bypass(in_a_wait, in_a_src, in_a, mem_valid, mem_tag, mem_data,
                        res_valid, res_tag, res_data);
  assign cap_b = bypass(in_b_wait, in_b_src, in_b, mem_valid, mem_tag, mem_data,
                        res_valid, res_tag, res_data);

  // occupancy and throttle
  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_vec[i]) free_cnt = free_cnt + CNT_W'(1);
    end
  end

  assign full     = (free_cnt <= CNT_W'(1));
  assign add_fire = run_en && in_valid && !full && free_any;

  rsa_pick #(.N(DEPTH)) u_free (
    .req   (~valid_vec),
    .grant (free_onehot),
    .idx   (add_slot),
    .any   (free_any)
  );

  rsa_pick #(.N(DEPTH)) u_issue (
    .req   (ready_vec),
    .grant (issue_vec),
    .idx   (issue_idx),
    .any   (issue_any)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rsa_slot #(
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W),
      .OP_W   (OP_W)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .run_en    (run_en),
      .wr_en     (add_fire && free_onehot[g]),
      .wr_op     (in_op),
      .wr_tag    (in_tag),
      .wr_a      (cap_a[DATA_W-1:0]),
      .wr_a_wait (cap_a[DATA_W]),
      .wr_a_src  (in_a_src),
      .wr_b      (cap_b[DATA_W-1:0]),
      .wr_b_wait (cap_b[DATA_W]),
      .wr_b_src  (in_b_src),
      .clr_en    (issue_vec[g]),
      .bc0_valid (mem_valid),
      .bc0_tag   (mem_tag),
      .bc0_data  (mem_data),
      .bc1_valid (res_valid),
      .bc1_tag   (res_tag),
      .bc1_data  (res_data),
      .valid     (valid_vec[g]),
      .ready     (ready_vec[g]),
      .op        (s_op[g]),
      .tag       (s_tag[g]),
      .a         (s_a[g]),
      .b         (s_b[g])
    );
  end

  rsa_alu #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .OP_W   (OP_W)
  ) u_alu (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .go        (issue_any),
    .op        (s_op[issue_idx]),
    .tag       (s_tag[issue_idx]),
    .a         (s_a[issue_idx]),
    .b         (s_b[issue_idx]),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .res_data  (res_data)
  );

endmodule

// File: rtl/rsa_station_chk.sv
module rsa_station_chk #(
  parameter int DEPTH  = 16,
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              in_valid,
  input logic              full,
  input logic              res_valid,
  input logic [DEPTH-1:0]  valid_vec,
  input logic [DEPTH-1:0]  issue_vec,
  input logic              issue_any,
  input logic              add_fire,
  input logic [SLOT_W-1:0] add_slot
);

  AST_RESET_EMPTIES: assert property (@(posedge clk)
    rst |=> (valid_vec == '0) && !res_valid); // R1

  AST_ADD_LANDS: assert property (@(posedge clk) disable iff (rst)
    add_fire |=> valid_vec[$past(add_slot)]); // R2

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_vec)); // R3

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (run_en && issue_any) |=> res_valid); // R3

  AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (rst)
    (run_en && issue_any && !add_fire)
      |=> ($countones(valid_vec) + 1 == $countones($past(valid_vec)))); // R3

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (run_en && in_valid && full)
      |=> ($countones(valid_vec) <= $countones($past(valid_vec)))); // R9

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(valid_vec) && $stable(res_valid)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (run_en && !issue_any) |=> !res_valid); // R11

endmodule

bind rsa_station rsa_station_chk #(
  .DEPTH  (DEPTH),
  .SLOT_W (SLOT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_en    (run_en),
  .in_valid  (in_valid),
  .full      (full),
  .res_valid (res_valid),
  .valid_vec (valid_vec),
  .issue_vec (issue_vec),
  .issue_any (issue_any),
  .add_fire  (add_fire),
  .add_slot  (add_slot)
);

// File: tb/sim_rsa_station.sv
module sim_rsa_station;

  logic        clk = 1'b0;
  logic        rst, run_en;
  logic        in_valid;
  logic [3:0]  in_op, in_tag, in_a_src, in_b_src;
  logic [31:0] in_a, in_b;
  logic        in_a_wait, in_b_wait;
  logic        full, res_valid;
  logic [3:0]  res_tag;
  logic [31:0] res_data;
  logic        mem_valid;
  logic [3:0]  mem_tag;
  logic [31:0] mem_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rsa_station u0 (
    .clk(clk), .rst(rst), .run_en(run_en),
    .in_valid(in_valid), .in_op(in_op), .in_tag(in_tag),
    .in_a(in_a), .in_a_wait(in_a_wait), .in_a_src(in_a_src),
    .in_b(in_b), .in_b_wait(in_b_wait), .in_b_src(in_b_src),
    .full(full), .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .mem_valid(mem_valid), .mem_tag(mem_tag), .mem_data(mem_data)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  32'd5,          32'd7,          32'd12},
    '{4'd0,  32'hFFFF_FFFF,  32'd1,          32'd0},
    '{4'd1,  32'd3,          32'd5,          32'hFFFF_FFFE},
    '{4'd2,  32'hF0F0_F0F0,  32'hFF00_FF00,  32'h0FF0_0FF0},
    '{4'd3,  32'hF0F0_F0F0,  32'h0F00_0000,  32'hFFF0_F0F0},
    '{4'd4,  32'hF0F0_F0F0,  32'hFF00_FF00,  32'hF000_F000},
    '{4'd5,  32'd1,          32'd31,         32'h8000_0000},
    '{4'd5,  32'd3,          32'h21,         32'd6},
    '{4'd6,  32'h8000_0000,  32'd4,          32'h0800_0000},
    '{4'd7,  32'h8000_0000,  32'd4,          32'hF800_0000},
    '{4'd8,  32'd5,          32'd5,          32'd1},
    '{4'd9,  32'd5,          32'd5,          32'd0},
    '{4'd10, 32'hFFFF_FFFF,  32'd1,          32'd1},
    '{4'd11, 32'hFFFF_FFFF,  32'd1,          32'd0},
    '{4'd12, 32'hFFFF_FFFF,  32'd1,          32'd0},
    '{4'd13, 32'hFFFF_FFFF,  32'd1,          32'd1},
    '{4'd14, 32'd7,          32'd9,          32'd0},
    '{4'd15, 32'd7,          32'd9,          32'd0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input logic [3:0] t, input logic [31:0] d);
    chk(req, "res_valid", {31'd0, res_valid}, 32'd1);
    chk(req, "res_tag",   {28'd0, res_tag},   {28'd0, t});
    chk(req, "res_data",  res_data,           d);
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "res_valid low", {31'd0, res_valid}, 32'd0);
  endtask

  // called at a negedge; returns at the negedge after the add edge
  task automatic drive_add(input logic [3:0] op, input logic [3:0] tg,
                           input logic [31:0] a, input logic aw, input logic [3:0] asrc,
                           input logic [31:0] b, input logic bw, input logic [3:0] bsrc);
    in_valid = 1'b1; in_op = op; in_tag = tg;
    in_a = a; in_a_wait = aw; in_a_src = asrc;
    in_b = b; in_b_wait = bw; in_b_src = bsrc;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL all watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; run_en = 1'b1; in_valid = 1'b0;
    in_op = '0; in_tag = '0; in_a = '0; in_b = '0;
    in_a_wait = 1'b0; in_b_wait = 1'b0; in_a_src = '0; in_b_src = '0;
    mem_valid = 1'b0; mem_tag = '0; mem_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_quiet("R1");
    chk("R1", "full after reset", {31'd0, full}, 32'd0);
    rst = 1'b0;

    // table walk: R4 / R5 encodings, R2 storage and R3 one-cycle latency
    for (int i = 0; i < NV; i++) begin
      drive_add(VECS[i].op, 4'(i), VECS[i].a, 1'b0, 4'd0, VECS[i].b, 1'b0, 4'd0);
      step();
      chk_res((VECS[i].op >= 4'd14) ? "R5" : "R4", 4'(i), VECS[i].exp);
    end
    step();
    chk_quiet("R11");

    // R6 load/store wakeup, R3 lowest slot first
    drive_add(4'd0, 4'd1, 32'd0, 1'b1, 4'd9, 32'd1, 1'b0, 4'd0);
    drive_add(4'd1, 4'd2, 32'd0, 1'b1, 4'd9, 32'd1, 1'b0, 4'd0);
    drive_add(4'd3, 4'd3, 32'd0, 1'b1, 4'd9, 32'd3, 1'b0, 4'd0);
    chk_quiet("R6");
    mem_valid = 1'b1; mem_tag = 4'd9; mem_data = 32'd100;
    step();
    mem_valid = 1'b0;
    chk_quiet("R11");
    step(); chk_res("R6", 4'd1, 32'd101);
    step(); chk_res("R3", 4'd2, 32'd99);
    step(); chk_res("R3", 4'd3, 32'd103);
    step(); chk_quiet("R11");

    // R7 wakeup from own previous result
    drive_add(4'd0, 4'd4, 32'd10, 1'b0, 4'd0, 32'd20, 1'b0, 4'd0);
    drive_add(4'd1, 4'd5, 32'd0, 1'b1, 4'd4, 32'd5, 1'b0, 4'd0);
    chk_res("R3", 4'd4, 32'd30);
    step(); chk_quiet("R7");
    step(); chk_res("R7", 4'd5, 32'd25);

    // R8 capture at add time from own result broadcast
    drive_add(4'd0, 4'd6, 32'd1, 1'b0, 4'd0, 32'd2, 1'b0, 4'd0);
    step(); chk_res("R3", 4'd6, 32'd3);
    drive_add(4'd0, 4'd7, 32'd0, 1'b1, 4'd6, 32'd4, 1'b0, 4'd0);
    step(); chk_res("R8", 4'd7, 32'd7);

    // R8 capture at add time from load/store broadcast
    mem_valid = 1'b1; mem_tag = 4'd12; mem_data = 32'd50;
    drive_add(4'd0, 4'd8, 32'd8, 1'b0, 4'd0, 32'd0, 1'b1, 4'd12);
    mem_valid = 1'b0;
    step(); chk_res("R8", 4'd8, 32'd58);

    // R9 full threshold and discarded add
    for (int k = 0; k < 15; k++) begin
      drive_add(4'd0, 4'(k), 32'd0, 1'b1, 4'd15, 32'(k), 1'b0, 4'd0);
      if (k == 13) chk("R9", "full with two free", {31'd0, full}, 32'd0);
      if (k == 14) chk("R9", "full with one free", {31'd0, full}, 32'd1);
    end
    drive_add(4'd0, 4'd3, 32'd1, 1'b0, 4'd0, 32'd1, 1'b0, 4'd0);
    step(); chk_quiet("R9");
    mem_valid = 1'b1; mem_tag = 4'd15; mem_data = 32'd0;
    step();
    mem_valid = 1'b0;
    for (int k = 0; k < 15; k++) begin
      step(); chk_res("R3", 4'(k), 32'(k));
    end
    step(); chk_quiet("R9");
    chk("R9", "full after drain", {31'd0, full}, 32'd0);

    // R10 freeze
    run_en = 1'b0;
    drive_add(4'd0, 4'd9, 32'd2, 1'b0, 4'd0, 32'd2, 1'b0, 4'd0);
    step();
    run_en = 1'b1;
    step(); step(); chk_quiet("R10");
    drive_add(4'd0, 4'd10, 32'd3, 1'b0, 4'd0, 32'd4, 1'b0, 4'd0);
    run_en = 1'b0;
    step(); chk_quiet("R10");
    run_en = 1'b1;
    step(); chk_res("R10", 4'd10, 32'd7);
    run_en = 1'b0;
    step(); chk_res("R10", 4'd10, 32'd7);
    run_en = 1'b1;
    step(); chk_quiet("R11");

    // R1 reset drops pending work
    drive_add(4'd0, 4'd11, 32'd0, 1'b1, 4'd13, 32'd1, 1'b0, 4'd0);
    rst = 1'b1;
    step();
    rst = 1'b0;
    mem_valid = 1'b1; mem_tag = 4'd13; mem_data = 32'd5;
    step();
    mem_valid = 1'b0;
    step(); chk_quiet("R1");
    step(); chk_quiet("R1");
    chk("R1", "full after mid reset", {31'd0, full}, 32'd0);

    finish_run();
  end

endmodule